// File: doc/BRIEF.md
# Serial In-System Programming Controller

This block is a synchronous programming slave. While its enable input is held high, it accepts serial commands on a clock/data pair and answers on a single output line. Both serial inputs are oversampled by the system clock. The serial clock must run at no more than one sixteenth of the system clock, and the block finds its edges by synchronising and comparing successive samples. Commands arrive as four-byte frames: a magic enable handshake, byte read and byte write, whole-array erase, lock-level raise, lock readback and signature readback. There is also a streaming page mode. In that mode an opcode and a page byte are followed by a full page of data bytes.

The block owns a byte-addressed program memory model and a four-level lock state. The lock can only be raised one level at a time, and only an erase clears it. At the two highest lock levels, signature reads return zero. The behaviour is organised around four states. `S_OFF` holds while enable is low. `S_SETTLE` waits for the serial clock to stay quiet. `S_CMD` shifts a four-byte frame or a page header. `S_PAGE` streams page data.

The transitions between states are as follows:
- Any state moves to `S_OFF` when enable drops.
- `S_OFF` moves to `S_SETTLE` when enable rises.
- `S_SETTLE` moves to `S_CMD` once the serial clock has been low for the settle window.
- `S_CMD` moves to `S_PAGE` when a page header completes while programming is enabled.
- `S_PAGE` moves to `S_CMD` after the last data byte of the page.

Top module: `isp_ctrl`

## Requirements
- R1: After enable rises, rising serial clock edges are ignored until the serial clock has been low for SETTLE_CLKS consecutive system clocks with enable high. An enable frame clocked in before that gets no echo, so its fourth byte reads 0x00.
- R2: Bytes are shifted MSB first. MOSI is sampled on the rising serial clock edge and MISO changes on the falling edge. MISO is 0 after reset and on every byte without a defined answer: the first three bytes of a four-byte frame and both header bytes of a page frame.
- R3: The frame 0xAC, 0x53, any, any returns 0x69 on its fourth byte and turns programming on. Until then, every other frame has no effect, returns 0x00, and is four bytes long.
- R4: Opcode 0x40 (address high, address low, data) stores the data at address {high,low} modulo 2^ADDR_W. Opcode 0x20 (address high, address low, any) returns the stored byte on the fourth byte. A byte that has never been written reads 0xFF.
- R5: The frame 0xAC, then a byte of the form 100x_xxxx, then two bytes of any value, sets every memory byte to 0xFF and returns the lock to mode 1.
- R6: The frame 0xAC, 1110_00ab, any, any requests lock mode ab+1. The request takes effect only when that mode is exactly one above the current mode. Opcode 0x24 returns a byte with bit0=lock bit 1, bit1=lock bit 2 and bit2=lock bit 3, each bit 1 when programmed: 0x00, 0x01, 0x03 and 0x07 for modes 1 to 4.
- R7: Opcode 0x28 (any, k, any) returns byte SIG_WORD[8*(k mod 4) +: 8] on the fourth byte, or 0x00 in lock modes 3 and 4.
- R8: Opcode 0x50 (page write) and opcode 0x30 (page read) are followed by a page byte p and then PAGE_BYTES data bytes for offsets 0 upward, at address {p, offset} modulo 2^ADDR_W. The byte after the last data byte is decoded as a new opcode.
- R9: Dropping enable aborts the frame in progress, clears the byte and bit counters and turns programming off. Memory and lock state are kept, and a new enable frame is needed after the settle window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low system reset |
| prog_en | input | 1 | Programming enable level; serial traffic is accepted only while high |
| sck | input | 1 | Serial clock, oversampled |
| mosi | input | 1 | Serial command and data input |
| miso | output | 1 | Serial response output |

## Verification
The bench builds the block with ADDR_W=7, PAGE_BYTES=16 and SETTLE_CLKS=64. The 128-byte memory and 16-byte pages let the bench stream complete pages for reading and writing, and check resynchronisation after a page, within a short run. The narrow address also makes aliasing of the address high byte observable through an ordinary byte read. Keeping the settle window at its full value of 64 exercises the real early-edge rejection case, and it still runs quickly.

// File: rtl/isp_pkg.sv
package isp_pkg;
    typedef enum logic [1:0] {
        S_OFF,
        S_SETTLE,
        S_CMD,
        S_PAGE
    } isp_state_t;

    localparam int          BYTE_W     = 8;
    localparam logic [7:0]  OP_PREFIX  = 8'hAC;
    localparam logic [7:0]  OP_ENABLE  = 8'h53;
    localparam logic [7:0]  ENABLE_ACK = 8'h69;
    localparam logic [7:0]  OP_RD_BYTE = 8'h20;
    localparam logic [7:0]  OP_WR_BYTE = 8'h40;
    localparam logic [7:0]  OP_RD_LOCK = 8'h24;
    localparam logic [7:0]  OP_RD_SIG  = 8'h28;
    localparam logic [7:0]  OP_RD_PAGE = 8'h30;
    localparam logic [7:0]  OP_WR_PAGE = 8'h50;
    localparam logic [7:0]  BLANK_BYTE = 8'hFF;
endpackage

// File: rtl/isp_sync_edge.sv
module isp_sync_edge #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en_in,
    input  logic sck_in,
    input  logic mosi_in,
    output logic en_s,
    output logic sck_s,
    output logic mosi_s,
    output logic sck_rise,
    output logic sck_fall
);
    logic [STAGES:0]   sck_q;
    logic [STAGES-1:0] en_q;
    logic [STAGES-1:0] mosi_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sck_q  <= '0;
            en_q   <= '0;
            mosi_q <= '0;
        end else begin
            sck_q  <= {sck_q[STAGES-1:0], sck_in};
            en_q   <= {en_q[STAGES-2:0], en_in};
            mosi_q <= {mosi_q[STAGES-2:0], mosi_in};
        end
    end

    assign en_s     = en_q[STAGES-1];
    assign sck_s    = sck_q[STAGES-1];
    assign mosi_s   = mosi_q[STAGES-1];
    assign sck_rise = sck_q[STAGES-1] & ~sck_q[STAGES];
    assign sck_fall = ~sck_q[STAGES-1] & sck_q[STAGES];
endmodule

// File: rtl/isp_shifter.sv
module isp_shifter #(
    parameter int BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              rise,
    input  logic              fall,
    input  logic              din,
    input  logic [BYTE_W-1:0] load_val,
    output logic [BYTE_W-1:0] rx_byte,
    output logic              byte_done,
    output logic              dout
);
    localparam int               CNT_W = $clog2(BYTE_W);
    localparam logic [CNT_W-1:0] LAST  = CNT_W'(BYTE_W - 1);

    logic [CNT_W-1:0]  bit_cnt;
    logic [BYTE_W-1:0] rx_sh;
    logic [BYTE_W-1:0] tx_sh;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bit_cnt   <= '0;
            rx_sh     <= '0;
            tx_sh     <= '0;
            byte_done <= 1'b0;
        end else if (clr) begin
            bit_cnt   <= '0;
            rx_sh     <= '0;
            tx_sh     <= '0;
            byte_done <= 1'b0;
        end else begin
            byte_done <= 1'b0;
            if (rise) begin
                rx_sh   <= {rx_sh[BYTE_W-2:0], din};
                bit_cnt <= bit_cnt + 1'b1;
                if (bit_cnt == LAST) begin
                    byte_done <= 1'b1;
                end
            end else if (fall) begin
                if (bit_cnt == '0) begin
                    tx_sh <= load_val;
                end else begin
                    tx_sh <= {tx_sh[BYTE_W-2:0], 1'b0};
                end
            end
        end
    end

    assign rx_byte = rx_sh;
    assign dout    = tx_sh[BYTE_W-1];
endmodule

// File: rtl/isp_prog_mem.sv
module isp_prog_mem #(
    parameter int ADDR_W = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic              erase,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [7:0]        wdata,
    input  logic [ADDR_W-1:0] raddr,
    output logic [7:0]        rdata
);
    import isp_pkg::*;

    localparam int DEPTH = 1 << ADDR_W;

    logic [7:0] cells [DEPTH];

    always_ff @(posedge clk) begin
        if (!rst_n || erase) begin
            for (int i = 0; i < DEPTH; i++) begin
                cells[i] <= BLANK_BYTE;
            end
        end else if (we) begin
            cells[waddr] <= wdata;
        end
    end

    assign rdata = cells[raddr];
endmodule

// File: rtl/isp_ctrl.sv
module isp_ctrl #(
    parameter int          ADDR_W      = 10,
    parameter int          PAGE_BYTES  = 256,
    parameter int          SETTLE_CLKS = 64,
    parameter logic [31:0] SIG_WORD    = 32'h4D_B2_17_E5
) (
    input  logic clk,
    input  logic rst_n,
    input  logic prog_en,
    input  logic sck,
    input  logic mosi,
    output logic miso
);
    import isp_pkg::*;

    localparam int PAGE_W = $clog2(PAGE_BYTES);
    localparam int SET_W  = $clog2(SETTLE_CLKS + 1);
    localparam int FULL_W = 8 + PAGE_W;

    isp_state_t        state, state_nx;
    logic [SET_W-1:0]  settle_cnt;
    logic [1:0]        byte_idx;
    logic [PAGE_W-1:0] page_off;
    logic [7:0]        b0, b1, b2;
    logic              enabled;
    logic [1:0]        lock_lvl;

    logic              en_s, sck_s, mosi_s, sck_rise, sck_fall;
    logic              armed, byte_done;
    logic [7:0]        rx_byte, resp, rdata, lock_byte, sig_byte;
    logic              frame_end, cmd_enable, cmd_erase, cmd_lock, lock_ok, is_page_op;
    logic              mem_we, mem_erase;
    logic [ADDR_W-1:0] byte_addr, page_addr, mem_addr;
    logic [FULL_W-1:0] page_full;

    isp_sync_edge #(.STAGES(2)) u_sync (
        .clk(clk), .rst_n(rst_n), .en_in(prog_en), .sck_in(sck), .mosi_in(mosi),
        .en_s(en_s), .sck_s(sck_s), .mosi_s(mosi_s),
        .sck_rise(sck_rise), .sck_fall(sck_fall)
    );

    assign armed = (state == S_CMD) || (state == S_PAGE);

    isp_shifter #(.BYTE_W(BYTE_W)) u_shift (
        .clk(clk), .rst_n(rst_n), .clr(~en_s),
        .rise(sck_rise & armed), .fall(sck_fall & armed), .din(mosi_s),
        .load_val(resp), .rx_byte(rx_byte), .byte_done(byte_done), .dout(miso)
    );

    // frame decode
    assign is_page_op = (b0 == OP_RD_PAGE) || (b0 == OP_WR_PAGE);
    assign frame_end  = byte_done && (state == S_CMD) && (byte_idx == 2'd3);
    assign cmd_enable = (b0 == OP_PREFIX) && (b1 == OP_ENABLE);
    assign cmd_erase  = enabled && (b0 == OP_PREFIX) && (b1[7:5] == 3'b100);
    assign cmd_lock   = enabled && (b0 == OP_PREFIX) && (b1[7:2] == 6'b111000);
    assign lock_ok    = cmd_lock && ({1'b0, b1[1:0]} == ({1'b0, lock_lvl} + 3'd1));

    assign page_full  = {b1, page_off};
    assign page_addr  = ADDR_W'(page_full);
    assign byte_addr  = ADDR_W'({b1, b2});
    assign mem_addr   = (state == S_PAGE) ? page_addr : byte_addr;
    assign mem_erase  = frame_end && cmd_erase;
    assign mem_we     = (frame_end && enabled && (b0 == OP_WR_BYTE)) ||
                        (byte_done && (state == S_PAGE) && (b0 == OP_WR_PAGE));

    isp_prog_mem #(.ADDR_W(ADDR_W)) u_mem (
        .clk(clk), .rst_n(rst_n), .we(mem_we), .erase(mem_erase),
        .waddr(mem_addr), .wdata(rx_byte), .raddr(mem_addr), .rdata(rdata)
    );

    assign lock_byte = {5'b0, lock_lvl == 2'd3, lock_lvl >= 2'd2, lock_lvl >= 2'd1};
    assign sig_byte  = SIG_WORD[{b2[1:0], 3'b000} +: 8];

    // answer presented for the byte now starting
    always_comb begin
        resp = '0;
        if (state == S_PAGE) begin
            if (b0 == OP_RD_PAGE) resp = rdata;
        end else if ((state == S_CMD) && (byte_idx == 2'd3)) begin
            if (cmd_enable) begin
                resp = ENABLE_ACK;
            end else if (enabled) begin
                if (b0 == OP_RD_BYTE)      resp = rdata;
                else if (b0 == OP_RD_LOCK) resp = lock_byte;
                else if (b0 == OP_RD_SIG)  resp = (lock_lvl >= 2'd2) ? 8'h00 : sig_byte;
            end
        end
    end

    // next state
    always_comb begin
        state_nx = state;
        unique case (state)
            S_OFF:    if (en_s) state_nx = S_SETTLE;
            S_SETTLE: if (!en_s) state_nx = S_OFF;
                      else if (!sck_s && (settle_cnt == SET_W'(SETTLE_CLKS - 1))) state_nx = S_CMD;
            S_CMD:    if (!en_s) state_nx = S_OFF;
                      else if (byte_done && (byte_idx == 2'd1) && enabled && is_page_op) state_nx = S_PAGE;
            S_PAGE:   if (!en_s) state_nx = S_OFF;
                      else if (byte_done && (page_off == PAGE_W'(PAGE_BYTES - 1))) state_nx = S_CMD;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state      <= S_OFF;
            settle_cnt <= '0;
        end else begin
            state <= state_nx;
            if ((state == S_SETTLE) && !sck_s) settle_cnt <= settle_cnt + 1'b1;
            else                               settle_cnt <= '0;
        end
    end

    // frame bookkeeping and lock state
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            byte_idx <= '0;
            page_off <= '0;
            b0       <= '0;
            b1       <= '0;
            b2       <= '0;
            enabled  <= 1'b0;
            lock_lvl <= '0;
        end else if (!en_s) begin
            byte_idx <= '0;
            page_off <= '0;
            enabled  <= 1'b0;
        end else if (byte_done && (state == S_CMD)) begin
            byte_idx <= byte_idx + 1'b1;
            unique case (byte_idx)
                2'd0: b0 <= rx_byte;
                2'd1: begin
                    b1 <= rx_byte;
                    if (enabled && is_page_op) begin
                        byte_idx <= '0;
                        page_off <= '0;
                    end
                end
                2'd2: b2 <= rx_byte;
                2'd3: begin
                    if (cmd_enable) enabled  <= 1'b1;
                    if (cmd_erase)  lock_lvl <= '0;
                    else if (lock_ok) lock_lvl <= b1[1:0];
                end
            endcase
        end else if (byte_done && (state == S_PAGE)) begin
            page_off <= page_off + 1'b1;
        end
    end
endmodule

// File: rtl/isp_ctrl_checker.sv
module isp_ctrl_checker #(
    parameter int SETTLE_CLKS = 64,
    parameter int SET_W       = 7,
    parameter int PAGE_W      = 8
) (
    input logic                clk,
    input logic                rst_n,
    input isp_pkg::isp_state_t state,
    input logic [SET_W-1:0]    settle_cnt,
    input logic [1:0]          byte_idx,
    input logic [PAGE_W-1:0]   page_off,
    input logic                enabled,
    input logic [1:0]          lock_lvl,
    input logic                mem_we,
    input logic                mem_erase,
    input logic                miso
);
    import isp_pkg::*;

    assert_settle_done_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_CMD && $past(state) == S_SETTLE) |-> ($past(settle_cnt) == SET_W'(SETTLE_CLKS - 1)));

    assert_page_needs_enable_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_PAGE) |-> enabled);

    assert_one_mem_op_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_we && mem_erase));

    assert_erase_unlocks_R5: assert property (@(posedge clk) disable iff (!rst_n)
        mem_erase |=> (lock_lvl == 2'd0));

    assert_lock_single_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (lock_lvl != $past(lock_lvl)) |->
            ((lock_lvl == $past(lock_lvl) + 2'd1) || (lock_lvl == 2'd0 && $past(mem_erase))));

    assert_page_from_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_PAGE && $past(state) != S_PAGE) |-> (page_off == '0));

    assert_quiet_when_off_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_OFF) |-> (!miso && !enabled && byte_idx == 2'd0));
endmodule

bind isp_ctrl isp_ctrl_checker #(
    .SETTLE_CLKS(SETTLE_CLKS), .SET_W(SET_W), .PAGE_W(PAGE_W)
) u_chk (
    .clk(clk), .rst_n(rst_n), .state(state), .settle_cnt(settle_cnt),
    .byte_idx(byte_idx), .page_off(page_off), .enabled(enabled),
    .lock_lvl(lock_lvl), .mem_we(mem_we), .mem_erase(mem_erase), .miso(miso)
);

// File: tb/isp_ctrl_bench.sv
`timescale 1ns/1ps
module isp_ctrl_bench;
    localparam int          AW   = 7;
    localparam int          PB   = 16;
    localparam int          SC   = 64;
    localparam logic [31:0] SIGW = 32'hC3_5A_96_1E;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic prog_en = 1'b0;
    logic sck = 1'b0;
    logic mosi = 1'b0;
    logic miso;

    always #10 clk = ~clk;

    isp_ctrl #(.ADDR_W(AW), .PAGE_BYTES(PB), .SETTLE_CLKS(SC), .SIG_WORD(SIGW)) u_isp_ctrl (
        .clk(clk), .rst_n(rst_n), .prog_en(prog_en), .sck(sck), .mosi(mosi), .miso(miso)
    );

    int    n_checks = 0;
    int    n_fail   = 0;
    bit    done     = 1'b0;
    bit    cmp_en   = 1'b0;
    logic  exp_miso = 1'b0;
    string cur_req  = "R2";

    // behavioural model
    logic [7:0] mdl_mem [int];
    int         mdl_lock = 0;
    bit         mdl_en   = 1'b0;
    bit         mdl_live = 1'b0;

    function automatic logic [7:0] mget(input int a);
        return mdl_mem.exists(a) ? mdl_mem[a] : 8'hFF;
    endfunction

    function automatic int baddr(input logic [7:0] hi, input logic [7:0] lo);
        return int'({hi, lo}) % (1 << AW);
    endfunction

    // compare MISO on every clock inside the stable window of each bit
    always begin
        @(posedge clk);
        #1;
        if (cmp_en) begin
            n_checks++;
            if (miso !== exp_miso) begin
                n_fail++;
                $display("FAIL %s: miso=%0b expected %0b at %0t", cur_req, miso, exp_miso, $time);
            end
        end
    end

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got %02h expected %02h", req, act, exp);
        end
    endtask

    task automatic send_byte(input logic [7:0] tx, input logic [7:0] exp);
        for (int i = 7; i >= 0; i--) begin
            sck    = 1'b0;
            mosi   = tx[i];
            cmp_en = 1'b0;
            repeat (4) @(negedge clk);
            exp_miso = exp[i];
            cmp_en   = 1'b1;
            repeat (4) @(negedge clk);
            sck = 1'b1;
            repeat (8) @(negedge clk);
        end
    endtask

    task automatic idle(input int n);
        sck    = 1'b0;
        cmp_en = 1'b0;
        repeat (n) @(negedge clk);
    endtask

    task automatic frame(input logic [7:0] c0, input logic [7:0] c1,
                         input logic [7:0] c2, input logic [7:0] c3, input string req);
        logic [7:0] r;
        r = 8'h00;
        if (mdl_live) begin
            if (c0 == 8'hAC && c1 == 8'h53) r = 8'h69;
            else if (mdl_en) begin
                if (c0 == 8'h20) r = mget(baddr(c1, c2));
                else if (c0 == 8'h24) r = {5'b0, mdl_lock >= 3, mdl_lock >= 2, mdl_lock >= 1};
                else if (c0 == 8'h28) r = (mdl_lock >= 2) ? 8'h00 : SIGW[8*(c2 % 4) +: 8];
            end
        end
        cur_req = req;
        send_byte(c0, 8'h00);
        send_byte(c1, 8'h00);
        send_byte(c2, 8'h00);
        send_byte(c3, r);
        if (mdl_live) begin
            if (c0 == 8'hAC && c1 == 8'h53) mdl_en = 1'b1;
            else if (mdl_en) begin
                if (c0 == 8'hAC && c1[7:5] == 3'b100) begin
                    mdl_mem.delete();
                    mdl_lock = 0;
                end else if (c0 == 8'hAC && c1[7:2] == 6'b111000) begin
                    if (int'(c1[1:0]) == mdl_lock + 1) mdl_lock++;
                end else if (c0 == 8'h40) begin
                    mdl_mem[baddr(c1, c2)] = c3;
                end
            end
        end
    endtask

    task automatic page(input logic [7:0] op, input logic [7:0] pg, input logic [7:0] seed, input string req);
        cur_req = req;
        send_byte(op, 8'h00);
        send_byte(pg, 8'h00);
        for (int k = 0; k < PB; k++) begin
            int          a;
            logic [7:0]  d;
            a = (int'(pg) * PB + k) % (1 << AW);
            d = seed + 8'(k * 7);
            if (op == 8'h30) send_byte(8'h00, mget(a));
            else begin
                send_byte(d, 8'h00);
                mdl_mem[a] = d;
            end
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: run did not finish");
            $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        chk("R2 reset miso", {7'b0, miso}, 8'h00);

        // R1: enable frame clocked in before the settle window is ignored
        prog_en = 1'b1;
        idle(10);
        mdl_live = 1'b0;
        frame(8'hAC, 8'h53, 8'h00, 8'h00, "R1 early frame");
        idle(SC + 20);
        mdl_live = 1'b1;

        // R3: before enable, commands are dead
        frame(8'h40, 8'h00, 8'h05, 8'h11, "R3 write while off");
        frame(8'h24, 8'h00, 8'h00, 8'h00, "R3 lock read while off");
        frame(8'hAC, 8'h53, 8'hA5, 8'h5A, "R3 enable echo");
        frame(8'h20, 8'h00, 8'h05, 8'h00, "R3 write while off had no effect");

        // R4: byte mode, blank value and aliasing of the high address byte
        frame(8'h20, 8'h00, 8'h44, 8'h00, "R4 blank read");
        frame(8'h40, 8'h00, 8'h05, 8'hA7, "R4 write");
        frame(8'h40, 8'h00, 8'h12, 8'h3C, "R4 write");
        frame(8'h20, 8'h00, 8'h05, 8'h00, "R4 read back");
        frame(8'h20, 8'h00, 8'h12, 8'h00, "R4 read back");
        frame(8'h40, 8'h01, 8'h05, 8'h99, "R4 aliased write");
        frame(8'h20, 8'h00, 8'h05, 8'h00, "R4 aliased read");

        // R7: signatures in mode 1
        for (int k = 0; k < 4; k++) frame(8'h28, 8'h00, 8'(k), 8'h00, "R7 signature");

        // R6: progressive lock
        frame(8'hAC, 8'hE2, 8'h00, 8'h00, "R6 skip to mode 3");
        frame(8'h24, 8'h00, 8'h00, 8'h00, "R6 lock after skip");
        frame(8'hAC, 8'hE1, 8'h00, 8'h00, "R6 mode 2");
        frame(8'h24, 8'h00, 8'h00, 8'h00, "R6 lock mode 2");
        frame(8'hAC, 8'hE3, 8'h00, 8'h00, "R6 skip to mode 4");
        frame(8'h28, 8'h00, 8'h01, 8'h00, "R7 signature mode 2");
        frame(8'hAC, 8'hE2, 8'h00, 8'h00, "R6 mode 3");
        frame(8'h24, 8'h00, 8'h00, 8'h00, "R6 lock mode 3");
        frame(8'h28, 8'h00, 8'h02, 8'h00, "R7 hidden mode 3");
        frame(8'hAC, 8'hE3, 8'h00, 8'h00, "R6 mode 4");
        frame(8'hAC, 8'hE0, 8'h00, 8'h00, "R6 lower request");
        frame(8'h24, 8'h00, 8'h00, 8'h00, "R6 lock mode 4");
        frame(8'h28, 8'h00, 8'h00, 8'h00, "R7 hidden mode 4");

        // R8: page streaming and resynchronisation
        page(8'h50, 8'h02, 8'h31, "R8 page write");
        frame(8'h20, 8'h00, 8'h23, 8'h00, "R8 decode after page");
        page(8'h30, 8'h02, 8'h00, "R8 page read");
        page(8'h30, 8'h03, 8'h00, "R8 blank page read");
        page(8'h50, 8'h0B, 8'hC0, "R8 aliased page write");
        page(8'h30, 8'h03, 8'h00, "R8 aliased page read");
        frame(8'h20, 8'h00, 8'h05, 8'h00, "R8 byte read after pages");

        // R5: erase
        frame(8'hAC, 8'h9F, 8'h00, 8'h00, "R5 erase");
        frame(8'h24, 8'h00, 8'h00, 8'h00, "R5 lock cleared");
        frame(8'h20, 8'h00, 8'h05, 8'h00, "R5 byte blank");
        page(8'h30, 8'h02, 8'h00, "R5 page blank");
        frame(8'h28, 8'h00, 8'h03, 8'h00, "R5 signature visible again");

        // R9: abort mid-frame
        frame(8'h40, 8'h00, 8'h09, 8'h55, "R9 setup write");
        frame(8'hAC, 8'hE1, 8'h00, 8'h00, "R9 setup lock");
        cur_req = "R9 partial frame";
        send_byte(8'h24, 8'h00);
        send_byte(8'h00, 8'h00);
        idle(2);
        prog_en = 1'b0;
        idle(10);
        chk("R9 miso low while off", {7'b0, miso}, 8'h00);
        prog_en = 1'b1;
        mdl_en  = 1'b0;
        idle(SC + 20);
        frame(8'h24, 8'h00, 8'h00, 8'h00, "R9 disabled after abort");
        frame(8'hAC, 8'hE2, 8'h00, 8'h00, "R9 lock request while off");
        frame(8'hAC, 8'h53, 8'h00, 8'h00, "R9 re-enable");
        frame(8'h24, 8'h00, 8'h00, 8'h00, "R9 lock kept");
        frame(8'h20, 8'h00, 8'h09, 8'h00, "R9 memory kept");
        idle(8);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    end
endmodule